// File: doc/BRIEF.md
# Dual fractional sample-rate strobe generator

This block turns a master-rate tick into a slower stream of single-cycle sample strobes. It holds two independent generators, one meant for playback and one for record. Each generator follows one of two master ticks, a 44.1 kHz tick or a 48 kHz tick. On every tick of its chosen master it adds a programmed increment to an accumulator. Each time the accumulator reaches a programmed modulus, it wraps and emits a strobe. The average output rate is therefore master × inc / mod. Typical settings use inc = 4 and mod = 4 × master / target. The master is picked as whichever of the two leaves the smaller remainder when divided by the target rate. This covers targets from 8 kHz to 48 kHz.

Each generator has two write-only registers. The first selects the master. The second packs the increment together with an encoded form of the modulus. Two converter ports each carry a clock-ID that chooses which generator's strobe they receive.

Top module: `bres_rate_gen`

## Requirements
- R1: After reset both generators use the 48 kHz master, with increment 0 and decoded modulus 0xFFFF, and no strobe appears on either converter output, whatever ticks arrive.
- R2: Control register 1 is `cfg_sel`=0. Bit 0 set selects `tick_441` as the master and clear selects `tick_480`. Ticks of the master that is not selected have no effect on the strobe output.
- R3: Control register 2 is `cfg_sel`=1. Bits 15:0 hold the increment and bits 31:16 hold (inc − mod − 1) modulo 2^16. The modulus used is inc − 1 − field, in 16-bit wrap-around arithmetic.
- R4: Each master tick adds inc to the accumulator. When the sum is at least mod, mod is subtracted and a one-cycle strobe appears in the cycle after the tick's clock edge. Starting from a cleared accumulator, N ticks give floor(N·inc/mod) strobes.
- R5: A write to either register of a generator clears its accumulator. A tick in the same cycle as such a write is discarded and gives no strobe.
- R6: A decoded modulus of 0, or an increment of 0, silences the generator.
- R7: With 0 < mod ≤ inc, every master tick gives a strobe and the accumulator stays at 0.
- R8: `cfg_gen` picks the generator a write reaches: 0 is the playback generator and 1 is the record generator. The other generator's state is untouched.
- R9: A clock-ID of 1 routes the playback generator's strobe, and a clock-ID of 2 routes the record generator's strobe. The values 0 and 3 give no strobe.
- R10: The accumulator stays below a nonzero modulus, so a generator emits at most one strobe per master tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_gen | input | 1 | Target generator of the write (0 playback, 1 record) |
| cfg_sel | input | 1 | Register select (0 master select, 1 increment/modulus) |
| cfg_wdata | input | 32 | Write data |
| tick_441 | input | 1 | One-cycle tick at the 44.1 kHz master rate |
| tick_480 | input | 1 | One-cycle tick at the 48 kHz master rate |
| play_clk_id | input | 2 | Generator choice for the playback converter |
| rec_clk_id | input | 2 | Generator choice for the record converter |
| play_strobe | output | 1 | Sample strobe for the playback converter |
| rec_strobe | output | 1 | Sample strobe for the record converter |

## Verification
A corrupted accumulator or a mis-decoded modulus shows up as a strobe shifted by one or more ticks. The first misplaced strobe appears within at most one modulus period of ticks after the fault, and it is compared against a bench model every cycle. A wrong master selection or a lost clear shows within a few ticks, as strobes following the wrong tick stream or arriving early after a write. Long directed runs also compare total strobe counts against floor(N·inc/mod), so slow rate drift cannot hide between individual edges.

// File: rtl/bres_pkg.sv
package bres_pkg;
  localparam int FW = 16;
  typedef logic [FW-1:0] fld_t;

  typedef struct packed {
    fld_t nxt;
    logic fire;
  } step_t;

  // modulus carried in the register as (inc - mod - 1); recover it
  function automatic fld_t mod_decode(fld_t inc, fld_t enc);
    return inc - fld_t'(1) - enc;
  endfunction

  // one accumulator step on a master tick
  function automatic step_t acc_step(fld_t acc, fld_t inc, fld_t md);
    step_t r;
    logic [FW:0] sum;
    logic [FW:0] dif;
    r.nxt  = acc;
    r.fire = 1'b0;
    sum    = {1'b0, acc} + {1'b0, inc};
    dif    = sum - {1'b0, md};
    if (md != '0 && inc != '0) begin
      if (inc >= md) begin
        r.nxt  = '0;
        r.fire = 1'b1;
      end else if (sum >= {1'b0, md}) begin
        r.nxt  = dif[FW-1:0];
        r.fire = 1'b1;
      end else begin
        r.nxt  = sum[FW-1:0];
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/bres_regs.sv
module bres_regs
  import bres_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic          sel,
  input  logic [2*FW-1:0] wdata,
  output logic          use_441,
  output fld_t          inc,
  output fld_t          md
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      use_441 <= 1'b0;
      inc     <= '0;
      md      <= mod_decode('0, '0);
    end else if (wr) begin
      if (!sel) begin
        use_441 <= wdata[0];
      end else begin
        inc <= wdata[FW-1:0];
        md  <= mod_decode(wdata[FW-1:0], wdata[2*FW-1:FW]);
      end
    end
  end
endmodule

// File: rtl/bres_accum.sv
module bres_accum
  import bres_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic tick,
  input  fld_t inc,
  input  fld_t md,
  output logic strobe,
  output fld_t acc
);
  step_t st;

  always_comb st = acc_step(acc, inc, md);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc    <= '0;
      strobe <= 1'b0;
    end else if (clear) begin
      acc    <= '0;
      strobe <= 1'b0;
    end else if (tick) begin
      acc    <= st.nxt;
      strobe <= st.fire;
    end else begin
      strobe <= 1'b0;
    end
  end
endmodule

// File: rtl/bres_route.sv
module bres_route #(
  parameter int NUM_GEN = 2,
  parameter int ID_W    = 2
) (
  input  logic [NUM_GEN-1:0] gen_strobe,
  input  logic [ID_W-1:0]    clk_id,
  output logic               strobe
);
  logic [NUM_GEN-1:0] hit;

  for (genvar k = 0; k < NUM_GEN; k++) begin : g_hit
    assign hit[k] = gen_strobe[k] && (clk_id == ID_W'(k + 1));
  end

  assign strobe = |hit;
endmodule

// File: rtl/bres_rate_gen.sv
module bres_rate_gen
  import bres_pkg::*;
#(
  parameter int NUM_GEN = 2,
  parameter int ID_W    = 2,
  localparam int GEN_W  = (NUM_GEN > 1) ? $clog2(NUM_GEN) : 1,
  localparam int DW     = 2 * FW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [GEN_W-1:0] cfg_gen,
  input  logic             cfg_sel,
  input  logic [DW-1:0]    cfg_wdata,
  input  logic             tick_441,
  input  logic             tick_480,
  input  logic [ID_W-1:0]  play_clk_id,
  input  logic [ID_W-1:0]  rec_clk_id,
  output logic             play_strobe,
  output logic             rec_strobe
);
  // per-generator events, named for the checker
  logic [NUM_GEN-1:0]         gen_clear;
  logic [NUM_GEN-1:0]         gen_tick;
  logic [NUM_GEN-1:0]         gen_strobe;
  logic [NUM_GEN-1:0]         gen_441;
  logic [NUM_GEN-1:0][FW-1:0] gen_inc;
  logic [NUM_GEN-1:0][FW-1:0] gen_mod;
  logic [NUM_GEN-1:0][FW-1:0] gen_acc;

  for (genvar g = 0; g < NUM_GEN; g++) begin : g_gen
    assign gen_clear[g] = cfg_we && (cfg_gen == GEN_W'(g));
    assign gen_tick[g]  = gen_441[g] ? tick_441 : tick_480;

    bres_regs u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr      (gen_clear[g]),
      .sel     (cfg_sel),
      .wdata   (cfg_wdata),
      .use_441 (gen_441[g]),
      .inc     (gen_inc[g]),
      .md      (gen_mod[g])
    );

    bres_accum u_acc (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear  (gen_clear[g]),
      .tick   (gen_tick[g]),
      .inc    (gen_inc[g]),
      .md     (gen_mod[g]),
      .strobe (gen_strobe[g]),
      .acc    (gen_acc[g])
    );
  end

  bres_route #(.NUM_GEN(NUM_GEN), .ID_W(ID_W)) u_play_route (
    .gen_strobe (gen_strobe),
    .clk_id     (play_clk_id),
    .strobe     (play_strobe)
  );

  bres_route #(.NUM_GEN(NUM_GEN), .ID_W(ID_W)) u_rec_route (
    .gen_strobe (gen_strobe),
    .clk_id     (rec_clk_id),
    .strobe     (rec_strobe)
  );
endmodule

// File: rtl/bres_rate_gen_chk.sv
module bres_rate_gen_chk #(
  parameter int NUM_GEN = 2,
  parameter int ID_W    = 2,
  parameter int FW      = 16
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [NUM_GEN-1:0]         gen_clear,
  input logic [NUM_GEN-1:0]         gen_tick,
  input logic [NUM_GEN-1:0]         gen_strobe,
  input logic [NUM_GEN-1:0][FW-1:0] gen_mod,
  input logic [NUM_GEN-1:0][FW-1:0] gen_acc,
  input logic [ID_W-1:0]            play_clk_id,
  input logic [ID_W-1:0]            rec_clk_id,
  input logic                       play_strobe,
  input logic                       rec_strobe
);
  for (genvar g = 0; g < NUM_GEN; g++) begin : g_chk
    p_strobe_follows_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
      gen_strobe[g] |-> $past(gen_tick[g]));

    p_clear_blocks_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
      gen_clear[g] |=> !gen_strobe[g]);

    p_zero_mod_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (gen_mod[g] == '0) |=> !gen_strobe[g]);

    p_acc_below_mod_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (gen_mod[g] != '0) |-> (gen_acc[g] < gen_mod[g]));
  end

  p_play_id_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (play_clk_id == '0 || play_clk_id == '1) |-> !play_strobe);

  p_rec_id_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_clk_id == '0 || rec_clk_id == '1) |-> !rec_strobe);

  p_play_needs_gen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    play_strobe |-> (gen_strobe != '0));
endmodule

bind bres_rate_gen bres_rate_gen_chk #(.NUM_GEN(NUM_GEN), .ID_W(ID_W), .FW(bres_pkg::FW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .gen_clear   (gen_clear),
  .gen_tick    (gen_tick),
  .gen_strobe  (gen_strobe),
  .gen_mod     (gen_mod),
  .gen_acc     (gen_acc),
  .play_clk_id (play_clk_id),
  .rec_clk_id  (rec_clk_id),
  .play_strobe (play_strobe),
  .rec_strobe  (rec_strobe)
);

// File: tb/bres_rate_gen_bench.sv
`timescale 1ns/1ps
module bres_rate_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [0:0]  cfg_gen = '0;
  logic        cfg_sel = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic        tick_441 = 1'b0;
  logic        tick_480 = 1'b0;
  logic [1:0]  play_clk_id = 2'd1;
  logic [1:0]  rec_clk_id = 2'd2;
  logic        play_strobe;
  logic        rec_strobe;

  always #2.5 clk = ~clk;

  bres_rate_gen u_bres_rate_gen (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_gen(cfg_gen),
    .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .tick_441(tick_441),
    .tick_480(tick_480), .play_clk_id(play_clk_id), .rec_clk_id(rec_clk_id),
    .play_strobe(play_strobe), .rec_strobe(rec_strobe)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  string cur_req = "R1";

  // bench model
  bit m_441 [2];
  int m_inc [2];
  int m_mod [2];
  int m_acc [2];
  bit m_fire[2];
  int cnt_play = 0;
  int cnt_rec  = 0;

  function automatic int enc_field(int inc, int md);
    return (inc - md - 1) & 16'hFFFF;
  endfunction

  function automatic bit routed(logic [1:0] id);
    if (id == 2'd1) return m_fire[0];
    if (id == 2'd2) return m_fire[1];
    return 1'b0;
  endfunction

  task automatic check(string req, string what, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s got %0d expected %0d", req, what, got, exp);
    end
  endtask

  task automatic model_update();
    for (int g = 0; g < 2; g++) begin
      bit t;
      m_fire[g] = 1'b0;
      if (cfg_we && cfg_gen == g[0:0]) begin
        if (!cfg_sel) m_441[g] = cfg_wdata[0];
        else begin
          m_inc[g] = cfg_wdata[15:0];
          m_mod[g] = (m_inc[g] + 65535 - int'(cfg_wdata[31:16])) % 65536;
        end
        m_acc[g] = 0;
      end else begin
        t = m_441[g] ? tick_441 : tick_480;
        if (t && m_mod[g] != 0 && m_inc[g] != 0) begin
          if (m_inc[g] >= m_mod[g]) begin
            m_acc[g] = 0;
            m_fire[g] = 1'b1;
          end else begin
            m_acc[g] += m_inc[g];
            if (m_acc[g] >= m_mod[g]) begin
              m_acc[g] -= m_mod[g];
              m_fire[g] = 1'b1;
            end
          end
        end
      end
    end
  endtask

  task automatic step();
    @(posedge clk);
    if (rst_n) model_update();
    @(negedge clk);
    check(cur_req, "play_strobe", play_strobe, routed(play_clk_id));
    check(cur_req, "rec_strobe", rec_strobe, routed(rec_clk_id));
    if (play_strobe) cnt_play++;
    if (rec_strobe) cnt_rec++;
  endtask

  task automatic wr(int g, bit sel, logic [31:0] d);
    cfg_we = 1'b1; cfg_gen = g[0:0]; cfg_sel = sel; cfg_wdata = d;
    step();
    cfg_we = 1'b0;
  endtask

  task automatic setup(int g, bit use441, int inc, int md);
    wr(g, 1'b0, {31'd0, use441});
    wr(g, 1'b1, {enc_field(inc, md)[15:0], inc[15:0]});
  endtask

  // master choice and modulus for a target rate with inc = 4
  task automatic pick(int rate, output bit use441, output int md);
    use441 = (44100 % rate) < (48000 % rate);
    md = 4 * (use441 ? 44100 : 48000) / rate;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired during %s", cur_req);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    bit u441; int md; int n480; int n441;
    void'($urandom(32'd1234));
    for (int g = 0; g < 2; g++) begin
      m_441[g] = 0; m_inc[g] = 0; m_mod[g] = 65535; m_acc[g] = 0; m_fire[g] = 0;
    end
    repeat (3) @(negedge clk);
    check("R1", "play_strobe in reset", play_strobe, 0);
    check("R1", "rec_strobe in reset", rec_strobe, 0);
    rst_n = 1'b1;
    // R1: reset config is silent with both ticks running
    cur_req = "R1";
    cnt_play = 0; cnt_rec = 0;
    for (int i = 0; i < 40; i++) begin
      tick_441 = 1'b1; tick_480 = 1'b1; step();
    end
    check("R1", "strobes after reset", cnt_play + cnt_rec, 0);

    // R2 R3 R4 R8: playback 8000 Hz, record 22050 Hz, with both tick streams
    cur_req = "R4";
    pick(8000, u441, md);
    check("R2", "8000 Hz picks 48k", u441, 0);
    check("R3", "8000 Hz modulus", md, 24);
    setup(0, u441, 4, md);
    pick(22050, u441, md);
    check("R2", "22050 Hz picks 44.1k", u441, 1);
    setup(1, u441, 4, md);
    cnt_play = 0; cnt_rec = 0; n480 = 0; n441 = 0;
    for (int i = 0; i < 480; i++) begin
      tick_480 = (i % 2 == 0); tick_441 = (i % 3 == 0);
      n480 += tick_480; n441 += tick_441;
      step();
    end
    tick_480 = 0; tick_441 = 0;
    check("R4", "playback strobe count", cnt_play, n480 * 4 / 24);
    check("R2", "record strobe count follows 44.1k", cnt_rec, n441 * 4 / 8);

    // R5: clear mid-accumulation, then tick on the write cycle
    cur_req = "R5";
    setup(0, 1'b0, 4, 24);
    for (int i = 0; i < 5; i++) begin tick_480 = 1; step(); end
    tick_480 = 1; wr(0, 1'b0, 32'd0);
    cnt_play = 0;
    for (int i = 0; i < 5; i++) begin tick_480 = 1; step(); end
    check("R5", "no strobe within 5 ticks after clear", cnt_play, 0);
    tick_480 = 1; step();
    check("R5", "strobe on 6th tick after clear", cnt_play, 1);
    tick_480 = 0;

    // R8: writing gen1 leaves gen0 running
    cur_req = "R8";
    cnt_play = 0;
    for (int i = 0; i < 30; i++) begin
      tick_480 = 1;
      if (i == 10) wr(1, 1'b1, 32'h0000_0003); else step();
    end
    tick_480 = 0;

    // R6: mod 0 and inc 0 silence
    cur_req = "R6";
    setup(0, 1'b0, 4, 0);
    setup(1, 1'b0, 0, 5);
    cnt_play = 0; cnt_rec = 0;
    for (int i = 0; i < 30; i++) begin tick_480 = 1; step(); end
    check("R6", "silent strobe count", cnt_play + cnt_rec, 0);

    // R7: inc >= mod
    cur_req = "R7";
    setup(0, 1'b0, 8, 4);
    setup(1, 1'b0, 6, 6);
    cnt_play = 0; cnt_rec = 0;
    for (int i = 0; i < 20; i++) begin tick_480 = (i % 2 == 0); step(); end
    check("R7", "playback strobe per tick", cnt_play, 10);
    check("R7", "record strobe per tick", cnt_rec, 10);
    tick_480 = 0;

    // R9: routing by clock-ID
    cur_req = "R9";
    play_clk_id = 2'd0; rec_clk_id = 2'd3;
    cnt_play = 0; cnt_rec = 0;
    for (int i = 0; i < 10; i++) begin tick_480 = 1; step(); end
    check("R9", "ids 0 and 3 give nothing", cnt_play + cnt_rec, 0);
    play_clk_id = 2'd2; rec_clk_id = 2'd1;
    for (int i = 0; i < 10; i++) begin tick_480 = 1; step(); end
    tick_480 = 0;

    // R10 R3: random mix
    cur_req = "R10";
    for (int i = 0; i < 3000; i++) begin
      tick_441 = ($urandom % 3) == 0;
      tick_480 = ($urandom % 2) == 0;
      if ($urandom % 16 == 0) begin
        play_clk_id = 2'($urandom); rec_clk_id = 2'($urandom);
      end
      if ($urandom % 60 == 0) begin
        int ri; int rm;
        ri = 1 + $urandom % 8; rm = 1 + $urandom % 40;
        cfg_we = 1; cfg_gen = 1'($urandom); cfg_sel = 1'($urandom);
        cfg_wdata = cfg_sel ? {enc_field(ri, rm)[15:0], ri[15:0]} : 32'($urandom);
        step();
        cfg_we = 0;
      end else begin
        step();
      end
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule